// File: doc/BRIEF.md
# Serial Register Port Slave

This block is the slave side of a four-pin serial control port. It gives a host read and write access to a small bank of 8-bit configuration registers. A host pulls chip select low and clocks in an instruction byte that holds a direction flag, a byte count and a 5-bit register address. It then moves between one and four data bytes. The block steps the register address on its own after each byte. The whole design runs on a fast system clock. The serial clock, chip select and data input are sampled on that clock, and edges of the serial clock are found by comparing each sample with the one before it.

Register 0 holds two mode bits. Bit 6 picks the bit order: 0 means most significant bit first, 1 means least significant bit first. The bit order also sets the address direction. MSB-first treats the given address as the top of the burst and counts down. LSB-first treats it as the bottom and counts up. Bit 7 picks where read data leaves the block. When it is 1, read data goes out on the shared data line and the separate output line is released. When it is 0, the shared line only receives and read data goes out on the separate output line. Output enables are reported as ports so that pad cells outside the block can build the tri-state drivers.

Top module: `spi_reg_port`

## Requirements
- R1: In MSB-first order the instruction arrives as R/W, N1, N0, A4, A3, A2, A1, A0, where R/W = 1 means read and 0 means write. Each data byte is sent bit 7 first.
- R2: When register 0 bit 6 is 1, every byte is sent bit 0 first: the instruction (A0 first, R/W last) and each data byte, in both directions.
- R3: The byte count field N1:N0 gives the number of data bytes as its value plus one, so 00 moves 1 byte and 11 moves 4.
- R4: After each data byte the address moves by one, modulo 32. It goes down in MSB-first order and up in LSB-first order.
- R5: A write byte reaches its register when its eighth bit is sampled. If chip select rises earlier, the partial byte is dropped and the next cycle starts again with an instruction.
- R6: Input bits are taken on the rising edge of the serial clock. Read data changes only on falling edges, so it is stable through the high half of the clock.
- R7: When register 0 bit 7 is 1, read data is enabled on the shared line and the separate output is disabled. When it is 0, the reverse holds.
- R8: While chip select is high, both output enables are low.
- R9: A new value written to register 0 changes the bit order and output line only from the next chip-select cycle. Any further bytes of the current burst keep the old settings.
- R10: Addresses at or above NUM_REGS read back as zero and ignore writes.
- R11: After reset every register is zero, which selects MSB-first order and the separate output line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Synchronous active-low reset |
| csb | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdioIn | input | 1 | Serial data in, the input side of the shared line |
| sdioOut | output | 1 | Read data for the shared line |
| sdioOe | output | 1 | Drive enable for the shared line |
| sdoOut | output | 1 | Read data for the separate output line |
| sdoOe | output | 1 | Drive enable for the separate output line |
| regsOut | output | NUM_REGS*8 | Register contents, register k at bits 8k+7:8k |

## Verification
Directed bursts are run in both bit orders. They start near address 0 and near 31 so that the count-down and count-up wrap points are both crossed, and they include addresses past the implemented bank. This separates errors in address direction, wrap and decode from errors in bit order. Separate directed cases cover three things: a write cut short by chip select, a read cut short by chip select, and a burst that rewrites register 0 in its first byte. These show whether partial bytes are dropped, whether outputs are released at once, and whether a mode change is held until the next cycle. Random bursts then mix all counts, addresses, directions and mode changes. Each one is compared against a register model kept in the bench.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       shiftEn;    // take one serial bit
    logic       instrDone;  // eighth instruction bit taken
    logic       writeByte;  // commit assembled byte
    logic       stepAddr;   // advance address after a data byte
    logic       launch;     // drive next read bit
    logic       lsbFirst;   // latched bit order for this cycle
    logic [2:0] bitIdx;     // rising edges seen in current byte
  } ctlStrobes_t;
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csb,
  input  logic        sclk,
  input  logic [7:0]  rxByte,
  input  logic [7:0]  cfgReg,
  output ctlStrobes_t st,
  output logic        sdioOe,
  output logic        sdoOe
);
  phase_e     phase;
  logic       sclkQ;
  logic [2:0] bitCnt;
  logic [1:0] bytesLeft;
  logic       isRead;
  logic       cfgLsb;
  logic       cfg3w;
  logic       sclkRise;
  logic       sclkFall;
  logic       lastBit;
  logic       readActive;

  assign sclkRise   = sclk & ~sclkQ & ~csb;
  assign sclkFall   = ~sclk & sclkQ & ~csb;
  assign lastBit    = sclkRise && (bitCnt == 3'd7);
  assign readActive = (phase == PH_DATA) && isRead;

  always_comb begin
    st.shiftEn   = sclkRise && (phase != PH_DONE);
    st.instrDone = lastBit && (phase == PH_INSTR);
    st.writeByte = lastBit && (phase == PH_DATA) && !isRead;
    st.stepAddr  = lastBit && (phase == PH_DATA);
    st.launch    = sclkFall && readActive;
    st.lsbFirst  = cfgLsb;
    st.bitIdx    = bitCnt;
  end

  assign sdioOe = ~csb & readActive & cfg3w;
  assign sdoOe  = ~csb & readActive & ~cfg3w;

  always_ff @(posedge clk) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      bytesLeft <= '0;
      isRead    <= 1'b0;
      cfgLsb    <= 1'b0;
      cfg3w     <= 1'b0;
    end else if (csb) begin
      // idle or abort: drop partial state, pick up new mode bits
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      bytesLeft <= '0;
      isRead    <= 1'b0;
      cfgLsb    <= cfgReg[6];
      cfg3w     <= cfgReg[7];
    end else begin
      if (st.shiftEn) bitCnt <= bitCnt + 3'd1;
      if (st.instrDone) begin
        isRead    <= rxByte[7];
        bytesLeft <= rxByte[6:5];
        phase     <= PH_DATA;
      end
      if (st.stepAddr) begin
        if (bytesLeft == 2'd0) phase <= PH_DONE;
        else                   bytesLeft <= bytesLeft - 2'd1;
      end
    end
  end

  // R7: never both lines driven
  a_r7_single_driver: assert property (@(posedge clk) disable iff (!rstN)
    !(sdioOe && sdoOe));

  // R9: mode bits frozen while chip select stays low
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!csb && $past(!csb)) |-> ($stable(cfgLsb) && $stable(cfg3w)));

  // R5: a raised chip select puts the FSM back to instruction phase
  a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    csb |=> (phase == PH_INSTR) && (bitCnt == 3'd0));
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                st,
  input  logic                       sdi,
  output logic [BYTE_W-1:0]          rxByte,
  output logic [BYTE_W-1:0]          cfgReg,
  output logic                       outBit,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

  logic [BYTE_W-1:0] shiftQ;
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] regFile [NUM_REGS];
  logic [NUM_REGS-1:0] wrEn;
  logic              addrHit;
  logic [BYTE_W-1:0] rdByte;
  logic [2:0]        txSel;

  assign rxByte  = st.lsbFirst ? {sdi, shiftQ[BYTE_W-1:1]} : {shiftQ[BYTE_W-2:0], sdi};
  assign addrHit = {1'b0, addrQ} < LIMIT;
  assign rdByte  = addrHit ? regFile[addrQ[IDX_W-1:0]] : '0;
  assign txSel   = st.lsbFirst ? st.bitIdx : ~st.bitIdx;
  assign cfgReg  = regFile[0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    assign wrEn[g] = st.writeByte && addrHit && (addrQ[IDX_W-1:0] == IDX_W'(g));
    assign regsOut[g*BYTE_W +: BYTE_W] = regFile[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wrEn[i]) regFile[i] <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      addrQ  <= '0;
      outBit <= 1'b0;
    end else begin
      if (st.shiftEn) shiftQ <= rxByte;
      if (st.instrDone)     addrQ <= rxByte[ADDR_W-1:0];
      else if (st.stepAddr) addrQ <= st.lsbFirst ? addrQ + 1'b1 : addrQ - 1'b1;
      if (st.launch) outBit <= rdByte[txSel];
    end
  end

  // R5: register contents move only on a committed byte
  a_r5_commit_only: assert property (@(posedge clk) disable iff (!rstN)
    !st.writeByte |=> $stable(regsOut));

  // R4: MSB-first steps down, LSB-first steps up, modulo 32
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepAddr && !st.lsbFirst) |=> addrQ == $past(addrQ) - 1'b1);
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepAddr && st.lsbFirst) |=> addrQ == $past(addrQ) + 1'b1);

  // R10: unimplemented addresses send zeros
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (st.launch && !addrHit) |=> !outBit);
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csb,
  input  logic                       sclk,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic                       sdoOut,
  output logic                       sdoOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  ctlStrobes_t       st;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] cfgReg;
  logic              outBit;

  spi_reg_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .csb    (csb),
    .sclk   (sclk),
    .rxByte (rxByte),
    .cfgReg (cfgReg),
    .st     (st),
    .sdioOe (sdioOe),
    .sdoOe  (sdoOe)
  );

  spi_reg_datapath #(.NUM_REGS(NUM_REGS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .sdi     (sdioIn),
    .rxByte  (rxByte),
    .cfgReg  (cfgReg),
    .outBit  (outBit),
    .regsOut (regsOut)
  );

  assign sdioOut = outBit;
  assign sdoOut  = outBit;

  // R8: outputs released whenever chip select is high
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    csb |-> (!sdioOe && !sdoOe));
endmodule

// File: tb/tb_spi_reg_port.sv
`timescale 1ns/1ps
module tb_spi_reg_port;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csb = 1'b1;
  logic sclk = 1'b0;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [NR*8-1:0] regsOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] model [32];

  always #10 clk = ~clk;

  spi_reg_port #(.NUM_REGS(NR)) dut (
    .clk(clk), .rstN(rstN), .csb(csb), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .regsOut(regsOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clkWait(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [7:0] rdModel(input logic [4:0] a);
    return (a < NR) ? model[a] : 8'h00;
  endfunction

  function automatic logic [NR*8-1:0] packModel();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic serBit(input logic [7:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  // one burst; cutBits >= 0 aborts after that many data bits
  task automatic xfer(input logic rw, input logic [1:0] n, input logic [4:0] a,
                      input logic [31:0] wd, input int cutBits, input string req);
    bit lsb = model[0][6];
    bit tw  = model[0][7];
    logic [7:0] instr = {rw, n, a};
    logic [4:0] cur = a;
    int sent = 0;
    csb = 1'b0;
    clkWait(2);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdioIn = serBit(instr, i, lsb); clkWait(4);
      sclk = 1'b1; clkWait(4);
    end
    for (int k = 0; k <= int'(n); k++) begin
      logic [7:0] got = '0;
      logic [7:0] exp = rdModel(cur);
      bit held = 1;
      for (int i = 0; i < 8; i++) begin
        logic lineBit;
        if (cutBits >= 0 && sent == cutBits) begin
          sclk = 1'b0; clkWait(2);
          csb = 1'b1; clkWait(1);
          check(!sdioOe && !sdoOe, "R8", "enables after abort", {sdioOe, sdoOe}, 0);
          clkWait(2);
          check(regsOut == packModel(), "R5", "regs after abort", regsOut, packModel());
          return;
        end
        sclk = 1'b0; sdioIn = serBit(wd[k*8 +: 8], i, lsb); clkWait(4);
        lineBit = tw ? sdioOut : sdoOut;
        if (rw && i == 0)
          check(sdioOe == tw && sdoOe == !tw, "R7", "read enables",
                {sdioOe, sdoOe}, {tw, !tw});
        got[lsb ? i : 7-i] = lineBit;
        sclk = 1'b1; clkWait(4);
        if ((tw ? sdioOut : sdoOut) != lineBit) held = 0;
        sent++;
      end
      if (rw) begin
        check(got == exp, lsb ? "R2" : "R1", $sformatf("read addr %0d", cur), got, exp);
        check(held, "R6", "data stable in high half", held, 1);
      end else if (cur < NR) begin
        model[cur] = wd[k*8 +: 8];
      end
      cur = lsb ? cur + 5'd1 : cur - 5'd1;
    end
    sclk = 1'b0; clkWait(2);
    csb = 1'b1; clkWait(3);
    check(regsOut == packModel(), req, "regs after burst", regsOut, packModel());
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    clkWait(5);
    rstN = 1'b1;
    clkWait(2);
    // R11: reset values
    check(regsOut == '0, "R11", "regs after reset", regsOut, 0);
    check(!sdioOe && !sdoOe, "R8", "enables idle", {sdioOe, sdoOe}, 0);

    // R1 R3 R4: MSB-first write of 4 bytes, counting down from 4
    xfer(1'b0, 2'd3, 5'd4, 32'h11_22_33_44, -1, "R3");
    check(regsOut[4*8 +: 8] == 8'h44 && regsOut[1*8 +: 8] == 8'h11, "R4",
          "down-step targets", {regsOut[4*8 +: 8], regsOut[1*8 +: 8]}, 16'h4411);
    xfer(1'b1, 2'd3, 5'd4, 32'h0, -1, "R1");
    // R4 wrap below zero; R10 address 31 ignored
    xfer(1'b0, 2'd2, 5'd1, 32'h99_15_A7, -1, "R10");
    xfer(1'b1, 2'd2, 5'd1, 32'h0, -1, "R10");
    // R9: switch to LSB-first and shared-line output; current burst MSB-first
    xfer(1'b0, 2'd0, 5'd0, 32'h0000_00C0, -1, "R9");
    check(regsOut[7:0] == 8'hC0, "R9", "mode byte written MSB-first", regsOut[7:0], 8'hC0);
    // R2 R4: LSB-first write counting up past the bank
    xfer(1'b0, 2'd3, 5'd6, 32'hDE_AD_5A_3C, -1, "R2");
    xfer(1'b1, 2'd3, 5'd30, 32'h0, -1, "R2");
    // R5: aborted write after 5 data bits, then an aborted read
    xfer(1'b0, 2'd0, 5'd3, 32'h0000_00FF, 5, "R5");
    xfer(1'b1, 2'd1, 5'd3, 32'h0, 3, "R8");
    xfer(1'b1, 2'd0, 5'd3, 32'h0, -1, "R5");
    // R9: burst rewrites mode in byte 0, byte 1 still LSB-first
    xfer(1'b0, 2'd1, 5'd0, 32'h0000_6E00, -1, "R9");
    xfer(1'b1, 2'd1, 5'd1, 32'h0, -1, "R9");

    // random bursts
    for (int t = 0; t < 60; t++) begin
      logic [4:0] a;
      int pick = $urandom % 10;
      a = (pick < 8) ? 5'(pick) : 5'(22 + pick);
      xfer(1'($urandom % 2), 2'($urandom % 4), a, $urandom, -1, "R4");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule